// File: doc/BRIEF.md
# Shared-Bus External FIFO Controller

This block is a bus master that moves 16-bit words between an internal stream and an external synchronous FIFO. The FIFO's data input and data output are wired to one shared bus. On that bus the controller drives words with an explicit drive enable and reads returned words back. The FIFO's write clock and read clock both run from the controller's own clock. The controller produces the active-low write strobe, read strobe and output enable. It samples the FIFO's active-low empty and full flags into registers and uses them to throttle transfers. Before any transfer is allowed, it pulses a reset line into the FIFO.

On the host side, write words arrive through a valid/ready handshake. A read word is fetched only while the consumer holds `rdReady` high, and it is handed over as a one-cycle `rdValid` pulse. Every pin toward the FIFO comes from a register. Direction changes always pass through an idle cycle, so the controller's drivers and the FIFO's output enable are never active together. The flags are sampled through a register and so arrive late. To cover that delay, each transfer is followed by two quiet cycles before the flags are trusted again.

Top module: `xfifo_bus_ctrl`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `wenN`, `renN`, `oeN` and `fifoRstN` are high, and `busDrive`, `wrReady` and `rdValid` are low.
- R2: Nothing is transferred until `start` is pulsed. After the pulse, `fifoRstN` is low for exactly RST_CYCLES (default 4) consecutive cycles. No strobe or `wrReady` occurs while it is low.
- R3: A write strobe (`wenN` low) never occurs while `fullN` is low. With the FIFO 8 deep and no reads, exactly 8 offered words are accepted.
- R4: A read strobe (`renN` low) never occurs while `emptyN` is low. Once the FIFO is drained, no further words are returned.
- R5: A word accepted on `wrData` (`wrValid` and `wrReady` both high at a clock edge) appears on `busOut` with `wenN` low and `busDrive` high in the next cycle. `wenN` is low only in such cycles.
- R6: Words come back on `rdData` in the order they were accepted, with none lost or duplicated.
- R7: `busDrive` is high only while `oeN` is high.
- R8: When `oeN` falls, `busDrive` is low in that cycle and in the cycle before it. When `busDrive` rises, `oeN` is high in that cycle and in the cycle before it.
- R9: After any strobe cycle, the next two cycles carry neither a write strobe nor a read strobe.
- R10: `rdValid` is high for one cycle, two cycles after a cycle with `renN` low, carrying the word the FIFO presented on `busIn`.
- R11: When the controller is idle and both a write (`wrValid` high, FIFO not full) and a read (`rdReady` high, FIFO not empty) are possible, the write burst is taken first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; also clocks the FIFO's write and read ports |
| rstN | input | 1 | Active-low synchronous reset of the controller |
| start | input | 1 | Pulse that resets the external FIFO and enables transfers |
| wrValid | input | 1 | Host write word is valid |
| wrData | input | 16 | Host write word |
| wrReady | output | 1 | Word on `wrData` is taken at this edge |
| rdReady | input | 1 | Consumer can take returned words |
| rdValid | output | 1 | One-cycle pulse: `rdData` holds a returned word |
| rdData | output | 16 | Word read from the FIFO |
| busIn | input | 16 | Shared bus as seen by the controller (FIFO output) |
| busOut | output | 16 | Value the controller places on the shared bus |
| busDrive | output | 1 | Controller's bus drivers enabled |
| wenN | output | 1 | Active-low FIFO write strobe |
| renN | output | 1 | Active-low FIFO read strobe |
| oeN | output | 1 | Active-low FIFO output enable |
| fifoRstN | output | 1 | Active-low FIFO reset |
| emptyN | input | 1 | Active-low FIFO empty flag |
| fullN | input | 1 | Active-low FIFO full flag |

## Verification
The properties assume that the FIFO's flags are truthful and synchronous to the clock. A flag reflects a write or read on the cycle after the edge that performed it. The properties also assume that the FIFO puts a popped word on the bus one cycle after the read edge, and only while output enable is low. The bench meets these assumptions with a cycle-based model of an 8-deep FIFO built to that contract. The model reports any strobe that reaches it while it is full or empty. Host inputs change one time unit after a rising edge and are held until the handshake completes.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_RST,
    ST_IDLE,
    ST_WRITE,
    ST_READ
  } ctrlState_e;

  // Strobes from control to datapath, registered onto the pins by the datapath.
  typedef struct packed {
    logic wrFire;
    logic rdFire;
    logic drive;
    logic oe;
    logic fifoRst;
  } strobe_t;

endpackage

// File: rtl/xfifo_ctrl.sv
module xfifo_ctrl
  import xfifo_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    wrValid,
  input  logic    rdReady,
  input  logic    emptyN,
  input  logic    fullN,
  output logic    wrReady,
  output strobe_t strobes
);

  // Quiet cycles after a strobe: one for the pin register, one for the flag register.
  localparam int HOLDOFF = 2;
  localparam int CW  = $clog2(HOLDOFF + 1);
  localparam int RCW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;

  ctrlState_e state;
  logic [CW-1:0]  cool;
  logic [RCW-1:0] rstCnt;
  logic emptyQ, fullQ;
  logic wrFire, rdFire;
  logic canWrite, canRead;

  assign canWrite = wrValid && fullQ;
  assign canRead  = rdReady && emptyQ;
  assign wrFire   = (state == ST_WRITE) && (cool == '0) && canWrite;
  assign rdFire   = (state == ST_READ)  && (cool == '0) && canRead;
  assign wrReady  = wrFire;

  always_comb begin
    strobes         = '0;
    strobes.wrFire  = wrFire;
    strobes.rdFire  = rdFire;
    strobes.drive   = (state == ST_WRITE);
    strobes.oe      = (state == ST_READ);
    strobes.fifoRst = (state == ST_RST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      emptyQ <= 1'b0;
      fullQ  <= 1'b0;
    end else begin
      emptyQ <= emptyN;
      fullQ  <= fullN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cool <= '0;
    end else if (wrFire || rdFire) begin
      cool <= CW'(HOLDOFF);
    end else if (cool != '0) begin
      cool <= cool - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_HOLD;
      rstCnt <= '0;
    end else begin
      unique case (state)
        ST_HOLD: if (start) begin
          state  <= ST_RST;
          rstCnt <= RCW'(RST_CYCLES - 1);
        end
        ST_RST: begin
          if (rstCnt == '0) state <= ST_IDLE;
          else              rstCnt <= rstCnt - 1'b1;
        end
        ST_IDLE: begin
          if (start) begin
            state  <= ST_RST;
            rstCnt <= RCW'(RST_CYCLES - 1);
          end else if (canWrite) begin
            state <= ST_WRITE;
          end else if (canRead) begin
            state <= ST_READ;
          end
        end
        ST_WRITE: if ((cool == '0) && !canWrite) state <= ST_IDLE;
        ST_READ:  if ((cool == '0) && !canRead)  state <= ST_IDLE;
        default:  state <= ST_HOLD;
      endcase
    end
  end

endmodule

// File: rtl/xfifo_dpath.sv
module xfifo_dpath
  import xfifo_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busDrive,
  output logic              wenN,
  output logic              renN,
  output logic              oeN,
  output logic              fifoRstN,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  logic wordOnBus;  // FIFO output holds the popped word during this cycle

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wenN     <= 1'b1;
      renN     <= 1'b1;
      oeN      <= 1'b1;
      busDrive <= 1'b0;
      fifoRstN <= 1'b1;
      busOut   <= '0;
    end else begin
      wenN     <= !strobes.wrFire;
      renN     <= !strobes.rdFire;
      oeN      <= !strobes.oe;
      busDrive <= strobes.drive;
      fifoRstN <= !strobes.fifoRst;
      if (strobes.wrFire) busOut <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordOnBus <= 1'b0;
      rdValid   <= 1'b0;
      rdData    <= '0;
    end else begin
      wordOnBus <= !renN;
      rdValid   <= wordOnBus;
      if (wordOnBus) rdData <= busIn;
    end
  end

endmodule

// File: rtl/xfifo_bus_ctrl.sv
module xfifo_bus_ctrl
  import xfifo_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrReady,
  input  logic              rdReady,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busDrive,
  output logic              wenN,
  output logic              renN,
  output logic              oeN,
  output logic              fifoRstN,
  input  logic              emptyN,
  input  logic              fullN
);

  strobe_t strobes;

  xfifo_ctrl #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .wrValid (wrValid),
    .rdReady (rdReady),
    .emptyN  (emptyN),
    .fullN   (fullN),
    .wrReady (wrReady),
    .strobes (strobes)
  );

  xfifo_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (wrData),
    .busIn    (busIn),
    .busOut   (busOut),
    .busDrive (busDrive),
    .wenN     (wenN),
    .renN     (renN),
    .oeN      (oeN),
    .fifoRstN (fifoRstN),
    .rdValid  (rdValid),
    .rdData   (rdData)
  );

endmodule

// File: rtl/xfifo_chk.sv
module xfifo_chk (
  input logic clk,
  input logic rstN,
  input logic wrReady,
  input logic rdValid,
  input logic busDrive,
  input logic wenN,
  input logic renN,
  input logic oeN,
  input logic fifoRstN,
  input logic emptyN,
  input logic fullN
);

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (wenN && renN && oeN && fifoRstN && !busDrive && !wrReady && !rdValid));

  a_r2_quiet_in_reset: assert property (@(posedge clk) disable iff (!rstN)
    !fifoRstN |-> (wenN && renN && oeN && !busDrive && !wrReady));

  a_r3_no_write_full: assert property (@(posedge clk) disable iff (!rstN)
    !wenN |-> fullN);

  a_r4_no_read_empty: assert property (@(posedge clk) disable iff (!rstN)
    !renN |-> emptyN);

  a_r5_write_drives: assert property (@(posedge clk) disable iff (!rstN)
    !wenN |-> busDrive);

  a_r7_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    busDrive |-> oeN);

  a_r8_gap_before_oe: assert property (@(posedge clk) disable iff (!rstN)
    $fell(oeN) |-> (!busDrive && !$past(busDrive)));

  a_r8_gap_before_drive: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busDrive) |-> (oeN && $past(oeN)));

  a_r9_quiet_next: assert property (@(posedge clk) disable iff (!rstN)
    (!wenN || !renN) |=> (wenN && renN));

  a_r9_quiet_second: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!wenN || !renN, 2) && $past(rstN, 2)) |-> (wenN && renN));

  a_r10_valid_after_read: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !$past(renN, 2));

endmodule

bind xfifo_bus_ctrl xfifo_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrReady  (wrReady),
  .rdValid  (rdValid),
  .busDrive (busDrive),
  .wenN     (wenN),
  .renN     (renN),
  .oeN      (oeN),
  .fifoRstN (fifoRstN),
  .emptyN   (emptyN),
  .fullN    (fullN)
);

// File: tb/sim_xfifo_bus_ctrl.sv
`timescale 1ns/1ps
module sim_xfifo_bus_ctrl;

  localparam int W     = 16;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic wrValid = 1'b0;
  logic [W-1:0] wrData = '0;
  logic rdReady = 1'b0;
  logic wrReady, rdValid, busDrive, wenN, renN, oeN, fifoRstN, emptyN, fullN;
  logic [W-1:0] rdData, busIn, busOut;

  always #5 clk = ~clk;

  xfifo_bus_ctrl u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .wrValid(wrValid), .wrData(wrData), .wrReady(wrReady),
    .rdReady(rdReady), .rdValid(rdValid), .rdData(rdData),
    .busIn(busIn), .busOut(busOut), .busDrive(busDrive),
    .wenN(wenN), .renN(renN), .oeN(oeN), .fifoRstN(fifoRstN),
    .emptyN(emptyN), .fullN(fullN)
  );

  int compared = 0;
  int mismatched = 0;
  int rdCount = 0;
  int wrCount = 0;
  logic [W-1:0] expQ[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // External FIFO model: flags follow the count, data appears one edge after a read.
  logic [W-1:0] mem [DEPTH];
  logic [3:0] cnt = '0;
  logic [2:0] wp = '0, rp = '0;
  logic [W-1:0] q = '0;
  assign emptyN = (cnt != 0);
  assign fullN  = (cnt != DEPTH);
  assign busIn  = oeN ? '0 : q;

  always @(posedge clk) begin
    if (!fifoRstN) begin
      cnt <= '0; wp <= '0; rp <= '0;
    end else begin
      if (!wenN) begin
        if (cnt == DEPTH) chk(1'b0, "R3 write into full FIFO", 32'(cnt), DEPTH - 1);
        else begin
          mem[wp] <= busOut; wp <= wp + 1'b1;
        end
      end
      if (!renN) begin
        if (cnt == 0) chk(1'b0, "R4 read from empty FIFO", 32'(cnt), 1);
        else begin
          q <= mem[rp]; rp <= rp + 1'b1;
        end
      end
      cnt <= cnt + 4'((!wenN && cnt != DEPTH) ? 1 : 0) - 4'((!renN && cnt != 0) ? 1 : 0);
    end
  end

  // Monitor: scoreboard pops and pin-level checks, away from the active edge.
  logic accPrev = 1'b0;
  logic [W-1:0] accPrevData = '0;
  logic prevDrive = 1'b0, prevOeN = 1'b1;
  logic [1:0] renHist = '0;
  int sinceStrobe = 100;

  always @(negedge clk) begin
    if (rstN) begin
      if (accPrev)
        chk(!wenN && busDrive && busOut == accPrevData, "R5 accepted word on bus", {15'd0, wenN, busOut}, {16'd0, accPrevData});
      else if (!wenN)
        chk(1'b0, "R5 strobe without accepted word", 32'(wenN), 1);
      accPrev     = wrValid && wrReady;
      accPrevData = wrData;

      if (rdValid) begin
        chk(renHist[1], "R10 rdValid two cycles after read strobe", 32'(renHist), 2);
        if (expQ.size() == 0) chk(1'b0, "R6 unexpected word", 32'(rdData), 0);
        else begin
          logic [W-1:0] e;
          e = expQ.pop_front();
          chk(rdData == e, "R6 read order", 32'(rdData), 32'(e));
        end
        rdCount++;
      end
      renHist = {renHist[0], !renN};

      if (busDrive) chk(oeN, "R7 drive with output enable", 32'(oeN), 1);
      if (prevOeN && !oeN) chk(!busDrive && !prevDrive, "R8 gap before output enable", {prevDrive, busDrive}, 0);
      if (!prevDrive && busDrive) chk(oeN && prevOeN, "R8 gap before drive", {prevOeN, oeN}, 3);
      prevDrive = busDrive;
      prevOeN   = oeN;

      if (!wenN || !renN) begin
        chk(sinceStrobe >= 3, "R9 strobe spacing", 32'(sinceStrobe), 3);
        sinceStrobe = 1;
      end else sinceStrobe++;
    end
  end

  // Driver: offers words, pushes each accepted one to the scoreboard.
  task automatic pushWords(input int n, input logic [W-1:0] base);
    for (int i = 0; i < n; i++) begin
      @(posedge clk) #1;
      wrValid = 1'b1;
      wrData  = base + W'(i);
      @(negedge clk);
      while (!wrReady) @(negedge clk);
      expQ.push_back(wrData);
      wrCount++;
    end
    @(posedge clk) #1 wrValid = 1'b0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      chk(1'b0, "watchdog expired", 32'(cyc), 20000);
      summary();
      $finish;
    end
  end

  initial begin
    int lowCycles;
    int accepted;
    int rdBefore;
    bit sawReady;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(wenN && renN && oeN && fifoRstN && !busDrive && !wrReady && !rdValid,
        "R1 reset state", {wenN, renN, oeN, fifoRstN, busDrive, wrReady, rdValid}, 7'b1111000);
    @(posedge clk) #1 rstN = 1'b1;
    @(negedge clk);
    chk(wenN && renN && oeN && fifoRstN && !busDrive && !wrReady,
        "R1 first cycle after reset", {wenN, renN, oeN, fifoRstN, busDrive, wrReady}, 6'b111100);

    // R2: an offered word before start is ignored
    @(posedge clk) #1 begin wrValid = 1'b1; wrData = 16'hBEEF; end
    sawReady = 1'b0;
    repeat (10) begin @(negedge clk); if (wrReady || !wenN) sawReady = 1'b1; end
    chk(!sawReady, "R2 no transfer before start", 32'(sawReady), 0);
    @(posedge clk) #1 begin wrValid = 1'b0; start = 1'b1; end
    @(posedge clk) #1 start = 1'b0;
    lowCycles = 0; sawReady = 1'b0;
    repeat (12) begin
      @(negedge clk);
      if (!fifoRstN) begin
        lowCycles++;
        if (wrReady || !wenN || !renN) sawReady = 1'b1;
      end
    end
    chk(lowCycles == 4, "R2 FIFO reset length", 32'(lowCycles), 4);
    chk(!sawReady, "R2 quiet during FIFO reset", 32'(sawReady), 0);

    // R5/R6: short burst, then read back
    pushWords(5, 16'h1000);
    repeat (10) @(posedge clk);
    #1 rdReady = 1'b1;
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk(expQ.size() == 0 && rdCount == 5, "R6 first burst returned", 32'(rdCount), 5);
    // R4: drained FIFO returns nothing more
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(rdCount == 5, "R4 no reads while empty", 32'(rdCount), 5);
    @(posedge clk) #1 rdReady = 1'b0;

    // R3: fill past depth with reads stopped
    accepted = wrCount;
    fork pushWords(12, 16'h2000); join_none
    repeat (80) @(posedge clk);
    @(negedge clk);
    chk(wrCount - accepted == DEPTH, "R3 accepted words when full", 32'(wrCount - accepted), DEPTH);
    @(posedge clk) #1 rdReady = 1'b1;
    wait fork;
    repeat (150) @(posedge clk);
    @(negedge clk);
    chk(expQ.size() == 0 && rdCount == wrCount, "R6 full-FIFO traffic returned", 32'(rdCount), 32'(wrCount));
    @(posedge clk) #1 rdReady = 1'b0;

    // R11: both directions possible from idle
    pushWords(3, 16'h3000);
    repeat (10) @(posedge clk);
    rdBefore = rdCount;
    #1 begin wrValid = 1'b1; wrData = 16'hC0DE; rdReady = 1'b1; end
    @(negedge clk);
    while (!wrReady) @(negedge clk);
    expQ.push_back(wrData);
    wrCount++;
    chk(renN && rdCount == rdBefore, "R11 write taken before read", 32'(rdCount), 32'(rdBefore));
    @(posedge clk) #1 wrValid = 1'b0;
    repeat (80) @(posedge clk);
    @(negedge clk);
    chk(expQ.size() == 0 && rdCount == wrCount, "R6 mixed traffic returned", 32'(rdCount), 32'(wrCount));

    summary();
    $finish;
  end

endmodule